// File: doc/BRIEF.md
# Burst Write Sequence Checking Slave

This block is a bus slave that keeps a 1024-word memory and, while storing every write, judges each incoming write burst against a sequence it derives from two programmed seed values. A burst is the run of accepted memory writes inside one assertion of the bus-cycle framing input. Beat k of a burst is expected at address `start + 4*k` and is expected to carry the start word rotated left by k bit positions. Only the first `limit` beats of a burst are judged. The limit is an 11-bit value. A mismatch sets an address flag or a data flag, or both. Each flag holds its value until software clears it.

Requests arrive on one valid/ready channel that carries reads and writes. A request transfers when framing, valid and ready are all high on a clock edge. Ready is low during reset and high from the first edge after reset, so the block never applies back-pressure once it is running. A master that sees ready low must hold its request. Every accepted read produces a response exactly one cycle later on a valid-only channel. That channel has no ready, and the master must take the response in that cycle. Address bit 12 picks the target: 0 selects the memory (word index from bits 11:2) and 1 selects the control registers (index from bits 4:2). The registers are: 0 start address, 1 start word, 2 beat limit, 3 error status, 4 burst count. The error status reads as {30'b0, address flag, data flag}, and a write to it clears both flags. The burst count counts closed bursts that held at least one memory write, and a write to it clears it.

Top module: `burst_check_slave`

## Requirements
- R1: During synchronous reset, req_ready_o, rsp_valid_o and both flags are 0. The start address, start word and limit reset to 0. req_ready_o is 1 from the first clock edge after reset is released.
- R2: An accepted write with address bit 12 = 0 stores its data at word index bits 11:2. An accepted read raises rsp_valid_o for exactly one cycle, in the cycle after acceptance, carrying the addressed word. rsp_valid_o is 0 in every other cycle.
- R3: Within a burst, an accepted memory write whose beat number k is below the limit sets addr_err_o if its address differs from start address + 4*k. The flag is visible the cycle after the beat.
- R4: Under the same condition as R3, data_err_o is set if the write data differs from the start word rotated left by k bits.
- R5: Memory writes with beat number at or above the limit are stored but set no flag.
- R6: Once set, a flag stays set through later bursts that have no errors.
- R7: A write to register 3 clears both flags. A read of register 3 returns bit 1 = address flag and bit 0 = data flag, with all other bits zero.
- R8: The burst count rises by one when the framing input is low after a burst that had at least one accepted memory write. A write to register 4 clears the count.
- R9: The expected sequence restarts at beat 0 for every new burst.
- R10: A request presented while the framing input is low is ignored. It writes nothing and produces no response.
- R11: Registers 0, 1 and 2 read back what was written to them. Register 2 keeps only the low 11 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc_i | input | 1 | Burst framing; high for the whole burst |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address; bit 12 selects registers |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read response data |
| addr_err_o | output | 1 | Sticky address-sequence error |
| data_err_o | output | 1 | Sticky data-sequence error |

## Verification
The assertions assume the inputs are known and free of X once reset is released. They also assume the master carries at most one request per clock on the shared channel, so a read and a write never share a cycle. Flag changes are traced only to accepted memory writes or to a clear of register 3. The stimulus drives every input at the falling edge and only through whole-cycle tasks. It holds the framing input high for the whole of each burst and closes each burst with an idle cycle. It reads only memory words that were written earlier.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned REG_IDX_W = 3;
  typedef enum logic [REG_IDX_W-1:0] {
    REG_START_ADDR = 3'd0,
    REG_START_DATA = 3'd1,
    REG_LIMIT      = 3'd2,
    REG_ERRORS     = 3'd3,
    REG_BURSTS     = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/bcs_store.sv
module bcs_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
    if (re_i) rdata_q <= mem[idx_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bcs_tracker.sv
module bcs_tracker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LIMIT_W = 11,
  localparam int unsigned STEP   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_i,
  input  logic               beat_i,
  input  logic [ADDR_W-1:0]  beat_addr_i,
  input  logic [DATA_W-1:0]  beat_data_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic [DATA_W-1:0]  start_data_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               clr_i,
  output logic               addr_err_o,
  output logic               data_err_o
);
  logic [LIMIT_W-1:0] beat_cnt;
  logic [ADDR_W-1:0]  exp_addr_q;
  logic [DATA_W-1:0]  exp_data_q;
  logic               aerr_q, derr_q;

  logic               first, judged;
  logic [ADDR_W-1:0]  cur_addr;
  logic [DATA_W-1:0]  cur_data;

  always_comb begin
    first    = (beat_cnt == '0);
    cur_addr = first ? start_addr_i : exp_addr_q;
    cur_data = first ? start_data_i : exp_data_q;
    judged   = beat_i && (beat_cnt < limit_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt   <= '0;
      exp_addr_q <= '0;
      exp_data_q <= '0;
      aerr_q     <= 1'b0;
      derr_q     <= 1'b0;
    end else begin
      if (!cyc_i) begin
        beat_cnt <= '0;
      end else if (judged) begin
        beat_cnt   <= beat_cnt + 1'b1;
        exp_addr_q <= cur_addr + ADDR_W'(STEP);
        exp_data_q <= {cur_data[DATA_W-2:0], cur_data[DATA_W-1]};
      end
      if (clr_i) begin
        aerr_q <= 1'b0;
        derr_q <= 1'b0;
      end else if (judged) begin
        if (beat_addr_i != cur_addr) aerr_q <= 1'b1;
        if (beat_data_i != cur_data) derr_q <= 1'b1;
      end
    end
  end

  assign addr_err_o = aerr_q;
  assign data_err_o = derr_q;
endmodule

// File: rtl/bcs_regs.sv
module bcs_regs
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LIMIT_W = 11,
  parameter int unsigned BURST_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  reg_sel_e           sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               ram_beat_i,
  input  logic               addr_err_i,
  input  logic               data_err_i,
  output logic [ADDR_W-1:0]  start_addr_o,
  output logic [DATA_W-1:0]  start_data_o,
  output logic [LIMIT_W-1:0] limit_o,
  output logic               clr_flags_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [ADDR_W-1:0]  start_addr_q;
  logic [DATA_W-1:0]  start_data_q;
  logic [LIMIT_W-1:0] limit_q;
  logic [BURST_W-1:0] bursts_q;
  logic               seen_q;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  always_comb begin
    unique case (sel_i)
      REG_START_ADDR: rd_mux = DATA_W'(start_addr_q);
      REG_START_DATA: rd_mux = start_data_q;
      REG_LIMIT:      rd_mux = {{(DATA_W-LIMIT_W){1'b0}}, limit_q};
      REG_ERRORS:     rd_mux = {{(DATA_W-2){1'b0}}, addr_err_i, data_err_i};
      REG_BURSTS:     rd_mux = {{(DATA_W-BURST_W){1'b0}}, bursts_q};
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr_q <= '0;
      start_data_q <= '0;
      limit_q      <= '0;
      bursts_q     <= '0;
      seen_q       <= 1'b0;
      rdata_q      <= '0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      if (!cyc_i) begin
        if (seen_q) bursts_q <= bursts_q + 1'b1;
        seen_q <= 1'b0;
      end else if (ram_beat_i) begin
        seen_q <= 1'b1;
      end
      if (wr_i) begin
        case (sel_i)
          REG_START_ADDR: start_addr_q <= ADDR_W'(wdata_i);
          REG_START_DATA: start_data_q <= wdata_i;
          REG_LIMIT:      limit_q      <= wdata_i[LIMIT_W-1:0];
          REG_BURSTS:     bursts_q     <= '0;
          default: ;
        endcase
      end
    end
  end

  assign clr_flags_o  = wr_i && (sel_i == REG_ERRORS);
  assign start_addr_o = start_addr_q;
  assign start_data_o = start_data_q;
  assign limit_o      = limit_q;
  assign rdata_o      = rdata_q;
endmodule

// File: rtl/burst_check_slave.sv
module burst_check_slave
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned LIMIT_W = 11,
  parameter int unsigned BURST_W = 16,
  parameter int unsigned SEL_BIT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              addr_err_o,
  output logic              data_err_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned WORD_LSB = $clog2(DATA_W / 8);

  logic ready_q, rsp_valid_q, rsp_ram_q;
  logic fire, to_reg;
  logic ram_wr, ram_rd, reg_wr, reg_rd;
  logic [IDX_W-1:0]   ram_idx;
  reg_sel_e           reg_sel;
  logic [DATA_W-1:0]  ram_rdata, reg_rdata;
  logic [ADDR_W-1:0]  start_addr;
  logic [DATA_W-1:0]  start_data;
  logic [LIMIT_W-1:0] limit;
  logic               clr_flags;

  always_comb begin
    fire    = bus_cyc_i && req_valid_i && ready_q;
    to_reg  = req_addr_i[SEL_BIT];
    ram_wr  = fire && req_write_i && !to_reg;
    ram_rd  = fire && !req_write_i && !to_reg;
    reg_wr  = fire && req_write_i && to_reg;
    reg_rd  = fire && !req_write_i && to_reg;
    ram_idx = req_addr_i[WORD_LSB +: IDX_W];
    reg_sel = reg_sel_e'(req_addr_i[WORD_LSB +: REG_IDX_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_ram_q   <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= ram_rd || reg_rd;
      if (ram_rd || reg_rd) rsp_ram_q <= ram_rd;
    end
  end

  bcs_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we_i    (ram_wr),
    .re_i    (ram_rd),
    .idx_i   (ram_idx),
    .wdata_i (req_wdata_i),
    .rdata_o (ram_rdata)
  );

  bcs_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT_W(LIMIT_W)) u_track (
    .clk          (clk),
    .rst          (rst),
    .cyc_i        (bus_cyc_i),
    .beat_i       (ram_wr),
    .beat_addr_i  (req_addr_i),
    .beat_data_i  (req_wdata_i),
    .start_addr_i (start_addr),
    .start_data_i (start_data),
    .limit_i      (limit),
    .clr_i        (clr_flags),
    .addr_err_o   (addr_err_o),
    .data_err_o   (data_err_o)
  );

  bcs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIMIT_W(LIMIT_W), .BURST_W(BURST_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cyc_i        (bus_cyc_i),
    .wr_i         (reg_wr),
    .rd_i         (reg_rd),
    .sel_i        (reg_sel),
    .wdata_i      (req_wdata_i),
    .ram_beat_i   (ram_wr),
    .addr_err_i   (addr_err_o),
    .data_err_i   (data_err_o),
    .start_addr_o (start_addr),
    .start_data_o (start_data),
    .limit_o      (limit),
    .clr_flags_o  (clr_flags),
    .rdata_o      (reg_rdata)
  );

  assign req_ready_o = ready_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_ram_q ? ram_rdata : reg_rdata;
endmodule

// File: rtl/burst_check_slave_sva.sv
module burst_check_slave_sva
  import bcs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEL_BIT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cyc_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              addr_err_o,
  input logic              data_err_o
);
  logic fire, mem_wr, clr_wr;
  always_comb begin
    fire   = bus_cyc_i && req_valid_i && req_ready_o;
    mem_wr = fire && req_write_i && !req_addr_i[SEL_BIT];
    clr_wr = fire && req_write_i && req_addr_i[SEL_BIT]
             && (req_addr_i[2 +: REG_IDX_W] == REG_ERRORS);
  end

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |=> req_ready_o);
  assert_read_answered_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !req_write_i) |=> rsp_valid_o);
  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !(fire && !req_write_i) |=> !rsp_valid_o);
  assert_addr_flag_cause_R3: assert property (@(posedge clk) disable iff (rst)
    (!addr_err_o && !mem_wr) |=> !addr_err_o);
  assert_data_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (!data_err_o && !mem_wr) |=> !data_err_o);
  assert_addr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (addr_err_o && !clr_wr) |=> addr_err_o);
  assert_data_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (data_err_o && !clr_wr) |=> data_err_o);
  assert_clear_both_R7: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (!addr_err_o && !data_err_o));
endmodule

bind burst_check_slave burst_check_slave_sva #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .bus_cyc_i   (bus_cyc_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .addr_err_o  (addr_err_o),
  .data_err_o  (data_err_o)
);

// File: tb/burst_check_slave_test.sv
`timescale 1ns/1ps
module burst_check_slave_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, vld = 1'b0, wr = 1'b0;
  logic [31:0] adr = '0, wdat = '0;
  logic rdy, rspv, aerr, derr;
  logic [31:0] rspd;

  always #5 clk = ~clk;

  burst_check_slave uut (
    .clk(clk), .rst(rst), .bus_cyc_i(cyc), .req_valid_i(vld), .req_ready_o(rdy),
    .req_write_i(wr), .req_addr_i(adr), .req_wdata_i(wdat), .rsp_valid_o(rspv),
    .rsp_rdata_o(rspd), .addr_err_o(aerr), .data_err_o(derr)
  );

  int total = 0, failed = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_mem [int];
  logic [31:0] m_sa, m_sd, m_rspd;
  int m_lim, m_beat, m_bursts;
  bit m_aerr, m_derr, m_seen, m_ready, m_rspv;

  localparam logic [31:0] REGS = 32'h0000_1000;
  localparam logic [31:0] SA   = 32'h0000_0100;
  localparam logic [31:0] SD   = 32'h8000_0001;

  function automatic logic [31:0] rotl(logic [31:0] d, int n);
    for (int i = 0; i < n; i++) d = {d[30:0], d[31]};
    return d;
  endfunction

  function automatic logic [31:0] reg_value(int idx);
    case (idx)
      0: return m_sa;
      1: return m_sd;
      2: return 32'(m_lim);
      3: return {30'd0, m_aerr, m_derr};
      4: return 32'(m_bursts);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit fire;
    if (rst) begin
      m_sa = 0; m_sd = 0; m_lim = 0; m_beat = 0; m_bursts = 0;
      m_aerr = 0; m_derr = 0; m_seen = 0; m_ready = 0; m_rspv = 0;
      return;
    end
    fire = cyc && vld && m_ready;
    m_rspv = 0;
    if (fire && !wr) begin
      m_rspv = 1;
      m_rspd = adr[12] ? reg_value(int'(adr[4:2])) : m_mem[int'(adr[11:2])];
    end
    if (fire && wr && !adr[12]) begin
      m_mem[int'(adr[11:2])] = wdat;
      m_seen = 1;
      if (m_beat < m_lim) begin
        if (adr != m_sa + 32'(4 * m_beat)) m_aerr = 1;
        if (wdat != rotl(m_sd, m_beat)) m_derr = 1;
        m_beat++;
      end
    end
    if (fire && wr && adr[12]) begin
      case (int'(adr[4:2]))
        0: m_sa = wdat;
        1: m_sd = wdat;
        2: m_lim = int'(wdat[10:0]);
        3: begin m_aerr = 0; m_derr = 0; end
        4: m_bursts = 0;
        default: ;
      endcase
    end
    if (!cyc) begin
      if (m_seen) m_bursts++;
      m_seen = 0;
      m_beat = 0;
    end
    m_ready = 1;
  endtask

  task automatic step(logic c, logic v, logic w, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    cyc = c; vld = v; wr = w; adr = a; wdat = d;
    @(posedge clk);
    model_edge();
    #1;
    chk(rdy === m_ready, "R1 ready", 32'(rdy), 32'(m_ready));
    chk(aerr === m_aerr, "R3 address flag", 32'(aerr), 32'(m_aerr));
    chk(derr === m_derr, "R4 data flag", 32'(derr), 32'(m_derr));
    chk(rspv === m_rspv, "R2 response valid", 32'(rspv), 32'(m_rspv));
    if (m_rspv) chk(rspd === m_rspd, "R2 response data", rspd, m_rspd);
  endtask

  task automatic idle();
    step(0, 0, 0, 32'd0, 32'd0);
  endtask

  task automatic wr_reg(int idx, logic [31:0] val);
    step(1, 1, 1, REGS | 32'(idx << 2), val);
    idle();
  endtask

  task automatic rd_check(logic [31:0] a, logic [31:0] exp, string what);
    step(1, 1, 0, a, 32'd0);
    chk(rspv === 1'b1 && rspd === exp, what, rspd, exp);
    idle();
  endtask

  // n beats from start; beat bad_a has a shifted address, beat bad_d inverted data
  task automatic burst(int n, int bad_a, int bad_d);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a, d;
      a = SA + 32'(4 * k);
      d = rotl(SD, k);
      if (k == bad_a) a = a - 32'd4;
      if (k == bad_d) d = ~d;
      step(1, 1, 1, a, d);
    end
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) idle();
    // R1: reset values
    chk(rdy === 1'b0 && aerr === 1'b0 && derr === 1'b0 && rspv === 1'b0,
        "R1 outputs in reset", {rdy, aerr, derr, rspv}, 32'd0);
    @(negedge clk); rst = 1'b0;
    idle();
    chk(rdy === 1'b1, "R1 ready after reset", 32'(rdy), 32'd1);
    rd_check(REGS | 32'(2 << 2), 32'd0, "R1 limit reset value");

    // R11: configuration registers
    wr_reg(0, SA);
    wr_reg(1, SD);
    wr_reg(2, 32'hFFFF_F804);  // low 11 bits = 4
    rd_check(REGS | 32'(0 << 2), SA, "R11 start address readback");
    rd_check(REGS | 32'(1 << 2), SD, "R11 start data readback");
    rd_check(REGS | 32'(2 << 2), 32'd4, "R11 limit keeps 11 bits");

    // R2 / R8: clean burst stored and counted
    burst(4, -1, -1);
    chk(aerr === 1'b0 && derr === 1'b0, "R3 clean burst no flag", {aerr, derr}, 32'd0);
    for (int k = 0; k < 4; k++)
      rd_check(SA + 32'(4 * k), rotl(SD, k), "R2 memory readback");
    rd_check(REGS | 32'(4 << 2), 32'd1, "R8 one burst counted");

    // R4: data error only
    burst(4, -1, 2);
    chk(derr === 1'b1 && aerr === 1'b0, "R4 data mismatch", {aerr, derr}, 32'd1);
    rd_check(REGS | 32'(3 << 2), 32'd1, "R7 status data bit 0");
    wr_reg(3, 32'd0);
    chk(derr === 1'b0 && aerr === 1'b0, "R7 clear flags", {aerr, derr}, 32'd0);

    // R3: address error on first beat
    burst(4, 0, -1);
    chk(aerr === 1'b1 && derr === 1'b0, "R3 address mismatch", {aerr, derr}, 32'd2);
    // R6: clean burst keeps flag
    burst(4, -1, -1);
    chk(aerr === 1'b1, "R6 flag stays set", 32'(aerr), 32'd1);
    rd_check(REGS | 32'(3 << 2), 32'd2, "R7 status address bit 1");

    // both errors in one burst
    burst(4, 3, 0);
    rd_check(REGS | 32'(3 << 2), 32'd3, "R7 status both bits");
    wr_reg(3, 32'hFFFF_FFFF);

    // R5: beats past limit are not judged but are stored
    burst(6, 4, 5);
    chk(aerr === 1'b0 && derr === 1'b0, "R5 beats past limit unchecked", {aerr, derr}, 32'd0);
    rd_check(SA + 32'd20, ~rotl(SD, 5), "R5 beat past limit stored");

    // R9: each burst restarts at beat 0
    burst(2, -1, -1);
    burst(2, -1, -1);
    chk(aerr === 1'b0 && derr === 1'b0, "R9 sequence restarts", {aerr, derr}, 32'd0);

    // R10: request without framing ignored
    step(0, 1, 1, SA, 32'hDEAD_BEEF);
    step(0, 1, 0, SA, 32'd0);
    chk(rspv === 1'b0, "R10 no response without framing", 32'(rspv), 32'd0);
    idle();
    rd_check(SA, rotl(SD, 0), "R10 unframed write ignored");

    // R8: counter clear
    rd_check(REGS | 32'(4 << 2), 32'(m_bursts), "R8 burst count total");
    wr_reg(4, 32'd0);
    rd_check(REGS | 32'(4 << 2), 32'd0, "R8 burst count cleared");

    repeat (2) idle();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule